// File: doc/BRIEF.md
# On-Screen Display Character Generator

This block lays a grid of text over a video raster. A pixel clock drives it. Its horizontal and vertical position counters restart on the rising edges of the incoming line and frame sync pulses. The text window opens at a programmable pixel and line offset. It holds a number of character rows, and each row is a fixed number of character columns wide. Each character cell is 14 pixels wide and 18 glyph lines tall. A programmable gap of 0 to 15 blank lines separates consecutive rows.

The block does not own the memories. For each pixel inside the window it presents a display-memory address for the cell under the beam. The 11-bit entry that comes back carries an 8-bit character code and a 3-bit palette index. From these the block forms a font-memory address. The font memory stores each glyph line as two 7-bit words, left half first, so every character takes 36 consecutive words. Both memories must answer in the same cycle as the address. The chosen glyph bit decides the pixel:
- A set bit shows the foreground colour, taken from an 8-entry palette by the cell's index.
- A clear bit shows the common background colour. It can instead be thinned to a checkerboard mesh.

A half-tone output can flag every background pixel. The blanking output tells the external video mixer when to switch to the overlay. All configuration arrives on static input ports. These are expected to change only while no text is being drawn.

Top module: `osd_chargen`

## Requirements
- R1: A rising edge on `hsync_i` sets the pixel counter to 0 at that clock edge. A rising edge on `vsync_i` sets the line counter to 0. When both edges arrive in the same cycle, the line counter still goes to 0. Every other `hsync_i` rising edge advances the line counter by one.
- R2: Horizontally, the window covers pixel counts `h_org_i` to `h_org_i + COLS*14 - 1`. Outside it, `r_o`, `g_o`, `b_o`, `blank_o` and `ht_o` are all 0.
- R3: Vertically, the window starts at line count `v_org_i`. It holds ROWS rows, each with a pitch of `18 + gap_i` lines. Glyph lines 0..17 of a row are drawn. The following `gap_i` lines are dark, like everything below the last row.
- R4: The cell at window row `row` and column `col` reads display address `row*COLS + col`. Bits [7:0] of the returned entry are the character code, and bits [10:8] are the palette index.
- R5: The font address is `code*36 + line*2 + half`. Here `half` is 0 for cell pixel columns 0..6 and 1 for columns 7..13.
- R6: Within a 7-bit font word, bit 6 is the leftmost pixel and bit 0 the rightmost.
- R7: A set glyph bit gives `{r_o,g_o,b_o}` = `pal_i[3*idx+2 : 3*idx]`, with `r_o` taken from the highest bit. It also gives `blank_o` = 1 and `ht_o` = 0.
- R8: A clear glyph bit that is not masked by the mesh gives `{r_o,g_o,b_o}` = `bg_i` and `blank_o` = 1.
- R9: With `mesh_en_i` = 1, a background pixel is masked when bit 0 of its cell pixel column differs from bit 0 of its glyph line. A masked pixel has colour 0 and `blank_o` = 0.
- R10: `ht_o` equals `ht_en_i` on every background pixel of a drawn glyph line, masked or not, and is 0 everywhere else.
- R11: With `osd_en_i` = 0, all five pixel outputs are 0.
- R12: Pixel outputs are registered and appear one clock after the counter state they belong to. During reset they are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Line sync, active on its rising edge, synchronous to clk |
| vsync_i | input | 1 | Frame sync, active on its rising edge, synchronous to clk |
| osd_en_i | input | 1 | Overlay enable |
| mesh_en_i | input | 1 | Checkerboard background mode |
| ht_en_i | input | 1 | Half-tone flag enable |
| h_org_i | input | HCNT_W | Pixel count of the first window column |
| v_org_i | input | VCNT_W | Line count of the first window line |
| gap_i | input | GAP_W | Blank lines between rows |
| bg_i | input | 3 | Background colour {R,G,B} |
| pal_i | input | 3*2**PAL_W | Foreground palette, entry k at bits [3k+2:3k] |
| disp_addr_o | output | DISP_AW | Display memory address |
| disp_data_i | input | CODE_W+PAL_W | Display memory entry, same-cycle read |
| font_addr_o | output | FONT_AW | Font memory address |
| font_data_i | input | HALF_W | Font memory word, same-cycle read |
| r_o | output | 1 | Red overlay pixel |
| g_o | output | 1 | Green overlay pixel |
| b_o | output | 1 | Blue overlay pixel |
| blank_o | output | 1 | Overlay switch, high where the overlay replaces the video |
| ht_o | output | 1 | Half-tone flag |

## Verification
The assertions depend on three things about the inputs:
- Both sync inputs are already in the pixel-clock domain.
- The two origins and the row gap stay put while a window is open. The start-position and line-range checks only hold for values that do not move under them.
- The origin plus the window width stays below the line length.

The bench follows all three. Every configuration change lands on the last cycle of a frame, when no window is open. Each sync pulse is held for several clocks. The horizontal origin is chosen so that the window ends before the next line sync.

// File: rtl/osd_pkg.sv
package osd_pkg;

   // One registered overlay pixel.
   typedef struct packed {
      logic [2:0] rgb;     // {R,G,B}
      logic       blank;   // overlay switch
      logic       ht;      // half-tone flag
   } osd_pix_t;

   localparam int OSD_COLOR_W = 3;

endpackage

// File: rtl/osd_span.sv
// Position tracker for one raster axis. A free counter restarts on clear_i
// and steps on tick_i. Once it reaches the origin, a minor counter (inside a
// cell) and a major counter (cell index) run until the last cell ends.
module osd_span #(
   parameter int CNT_W   = 10,
   parameter int MINOR_W = 4,
   parameter int N_MAJOR = 24,
   localparam int MAJOR_W = $clog2(N_MAJOR)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               tick_i,
   input  logic [CNT_W-1:0]   origin_i,
   input  logic [MINOR_W-1:0] last_minor_i,
   output logic               act_o,
   output logic [MINOR_W-1:0] minor_o,
   output logic [MAJOR_W-1:0] major_o
);

   if (N_MAJOR < 2) begin : g_chk_major
      $error("osd_span: N_MAJOR must be at least 2");
   end
   if (CNT_W < 2 || MINOR_W < 1) begin : g_chk_width
      $error("osd_span: counter widths too small");
   end

   localparam logic [MAJOR_W-1:0] MAJOR_LAST = MAJOR_W'(N_MAJOR - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_next;
   logic             cnt_full;
   logic             start;
   logic             minor_wrap;
   logic             major_last;

   always_comb begin
      cnt_full   = (cnt == {CNT_W{1'b1}});
      cnt_next   = cnt_full ? cnt : cnt + 1'b1;
      start      = tick_i && !cnt_full && (cnt_next == origin_i);
      minor_wrap = (minor_o == last_minor_i);
      major_last = (major_o == MAJOR_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         act_o   <= 1'b0;
         minor_o <= '0;
         major_o <= '0;
      end else if (clear_i) begin
         cnt     <= '0;
         act_o   <= (origin_i == '0);
         minor_o <= '0;
         major_o <= '0;
      end else if (tick_i) begin
         cnt <= cnt_next;
         if (start) begin
            act_o   <= 1'b1;
            minor_o <= '0;
            major_o <= '0;
         end else if (act_o) begin
            if (minor_wrap) begin
               minor_o <= '0;
               if (major_last) begin
                  act_o   <= 1'b0;
                  major_o <= '0;
               end else begin
                  major_o <= major_o + 1'b1;
               end
            end else begin
               minor_o <= minor_o + 1'b1;
            end
         end
      end
   end

   // R1: a sync edge restarts the position from zero
   a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt == '0 && minor_o == '0 && major_o == '0));

   // R2/R3: the window opens exactly at the programmed origin
   a_r2_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(act_o) && $stable(origin_i)) |-> (cnt == origin_i));

   // R2/R3: the cell index never leaves the grid
   a_r2_major_bound: assert property (@(posedge clk) disable iff (!rst_n)
      act_o |-> (major_o <= MAJOR_LAST));

   // R3: the line inside a row never exceeds the pitch
   a_r3_minor_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (act_o && $stable(last_minor_i)) |-> (minor_o <= last_minor_i));

endmodule

// File: rtl/osd_pixel.sv
// Memory addressing for the cell under the beam, glyph bit selection,
// colour choice and the output register.
module osd_pixel
   import osd_pkg::*;
#(
   parameter int COLS      = 24,
   parameter int ROWS      = 10,
   parameter int CELL_H    = 18,
   parameter int HALF_W    = 7,
   parameter int CODE_W    = 8,
   parameter int PAL_W     = 3,
   parameter int PX_W      = 4,
   parameter int LINE_W    = 6,
   parameter bit LEFT_MSB  = 1'b1,
   localparam int COL_W    = $clog2(COLS),
   localparam int ROW_W    = $clog2(ROWS),
   localparam int DISP_W   = CODE_W + PAL_W,
   localparam int DISP_AW  = $clog2(ROWS * COLS),
   localparam int WPC      = 2 * CELL_H,
   localparam int FONT_AW  = $clog2((2 ** CODE_W) * WPC),
   localparam int PAL_BITS = OSD_COLOR_W * (2 ** PAL_W)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   osd_en_i,
   input  logic                   mesh_en_i,
   input  logic                   ht_en_i,
   input  logic [OSD_COLOR_W-1:0] bg_i,
   input  logic [PAL_BITS-1:0]    pal_i,
   input  logic                   hact_i,
   input  logic [PX_W-1:0]        px_i,
   input  logic [COL_W-1:0]       col_i,
   input  logic                   vact_i,
   input  logic [LINE_W-1:0]      line_i,
   input  logic [ROW_W-1:0]       row_i,
   output logic [DISP_AW-1:0]     disp_addr_o,
   input  logic [DISP_W-1:0]      disp_data_i,
   output logic [FONT_AW-1:0]     font_addr_o,
   input  logic [HALF_W-1:0]      font_data_i,
   output osd_pix_t               pix_o
);

   logic                   in_cell;
   logic [CODE_W-1:0]      code;
   logic [PAL_W-1:0]       pidx;
   logic                   half;
   logic [PX_W-1:0]        sub;
   logic [PX_W-1:0]        sel;
   logic [HALF_W-1:0]      shifted;
   logic                   glyph_on;
   logic                   meshed;
   logic [OSD_COLOR_W-1:0] fg;

   always_comb begin
      in_cell     = hact_i && vact_i && (line_i < LINE_W'(CELL_H));
      disp_addr_o = DISP_AW'(row_i) * DISP_AW'(COLS) + DISP_AW'(col_i);
      code        = disp_data_i[CODE_W-1:0];
      pidx        = disp_data_i[CODE_W +: PAL_W];
      half        = (px_i >= PX_W'(HALF_W));
      sub         = half ? px_i - PX_W'(HALF_W) : px_i;
      font_addr_o = FONT_AW'(code) * FONT_AW'(WPC) + FONT_AW'({line_i, half});
      fg          = OSD_COLOR_W'(pal_i >> (OSD_COLOR_W * int'(pidx)));
      meshed      = mesh_en_i && (px_i[0] ^ line_i[0]);
   end

   // Bit order inside a font word is a build option.
   if (LEFT_MSB) begin : g_msb_left
      assign sel = PX_W'(HALF_W - 1) - sub;
   end else begin : g_lsb_left
      assign sel = sub;
   end

   assign shifted  = font_data_i >> sel;
   assign glyph_on = shifted[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_o <= '0;
      end else if (!osd_en_i || !in_cell) begin
         pix_o <= '0;
      end else if (glyph_on) begin
         pix_o.rgb   <= fg;
         pix_o.blank <= 1'b1;
         pix_o.ht    <= 1'b0;
      end else begin
         pix_o.ht <= ht_en_i;
         if (meshed) begin
            pix_o.rgb   <= '0;
            pix_o.blank <= 1'b0;
         end else begin
            pix_o.rgb   <= bg_i;
            pix_o.blank <= 1'b1;
         end
      end
   end

   // R11: a disabled overlay stays dark
   a_r11_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !osd_en_i |=> (pix_o == '0));

   // R2: nothing is drawn left or right of the window
   a_r2_outside_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !hact_i |=> (!pix_o.blank && !pix_o.ht));

   // R3: gap lines between rows stay dark
   a_r3_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (vact_i && line_i >= LINE_W'(CELL_H)) |=> (!pix_o.blank && !pix_o.ht));

   // R10: the half-tone flag needs its enable
   a_r10_ht_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !ht_en_i |=> !pix_o.ht);

   // R9/R12: whenever the overlay switch is low, the colour is black
   a_r12_clear_is_black: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_o.blank |-> (pix_o.rgb == '0));

endmodule

// File: rtl/osd_chargen.sv
module osd_chargen
   import osd_pkg::*;
#(
   parameter int COLS     = 24,
   parameter int ROWS     = 10,
   parameter int CELL_W   = 14,
   parameter int CELL_H   = 18,
   parameter int HALF_W   = 7,
   parameter int CODE_W   = 8,
   parameter int PAL_W    = 3,
   parameter int GAP_W    = 4,
   parameter int HCNT_W   = 10,
   parameter int VCNT_W   = 9,
   parameter bit LEFT_MSB = 1'b1,
   localparam int DISP_W   = CODE_W + PAL_W,
   localparam int DISP_AW  = $clog2(ROWS * COLS),
   localparam int FONT_AW  = $clog2((2 ** CODE_W) * 2 * CELL_H),
   localparam int PAL_BITS = OSD_COLOR_W * (2 ** PAL_W)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hsync_i,
   input  logic                   vsync_i,
   input  logic                   osd_en_i,
   input  logic                   mesh_en_i,
   input  logic                   ht_en_i,
   input  logic [HCNT_W-1:0]      h_org_i,
   input  logic [VCNT_W-1:0]      v_org_i,
   input  logic [GAP_W-1:0]       gap_i,
   input  logic [OSD_COLOR_W-1:0] bg_i,
   input  logic [PAL_BITS-1:0]    pal_i,
   output logic [DISP_AW-1:0]     disp_addr_o,
   input  logic [DISP_W-1:0]      disp_data_i,
   output logic [FONT_AW-1:0]     font_addr_o,
   input  logic [HALF_W-1:0]      font_data_i,
   output logic                   r_o,
   output logic                   g_o,
   output logic                   b_o,
   output logic                   blank_o,
   output logic                   ht_o
);

   localparam int PX_W   = $clog2(CELL_W);
   localparam int LINE_W = $clog2(CELL_H + 2 ** GAP_W - 1);
   localparam int COL_W  = $clog2(COLS);
   localparam int ROW_W  = $clog2(ROWS);

   if (CELL_W != 2 * HALF_W) begin : g_chk_cell
      $error("osd_chargen: a cell line must be exactly two font words");
   end
   if (2 ** HCNT_W <= COLS * CELL_W) begin : g_chk_hcnt
      $error("osd_chargen: HCNT_W too narrow for the window width");
   end
   if (2 ** VCNT_W <= ROWS * CELL_H) begin : g_chk_vcnt
      $error("osd_chargen: VCNT_W too narrow for the window height");
   end

   logic hs_q, vs_q;
   logic hs_rise, vs_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         vs_q <= 1'b0;
      end else begin
         hs_q <= hsync_i;
         vs_q <= vsync_i;
      end
   end

   assign hs_rise = hsync_i && !hs_q;
   assign vs_rise = vsync_i && !vs_q;

   logic              hact, vact;
   logic [PX_W-1:0]   px;
   logic [COL_W-1:0]  col;
   logic [LINE_W-1:0] line;
   logic [ROW_W-1:0]  row;
   logic [LINE_W-1:0] line_last;
   osd_pix_t          pix;

   assign line_last = LINE_W'(CELL_H - 1) + LINE_W'(gap_i);

   osd_span #(
      .CNT_W   (HCNT_W),
      .MINOR_W (PX_W),
      .N_MAJOR (COLS)
   ) u_hspan (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (hs_rise),
      .tick_i       (1'b1),
      .origin_i     (h_org_i),
      .last_minor_i (PX_W'(CELL_W - 1)),
      .act_o        (hact),
      .minor_o      (px),
      .major_o      (col)
   );

   osd_span #(
      .CNT_W   (VCNT_W),
      .MINOR_W (LINE_W),
      .N_MAJOR (ROWS)
   ) u_vspan (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (vs_rise),
      .tick_i       (hs_rise),
      .origin_i     (v_org_i),
      .last_minor_i (line_last),
      .act_o        (vact),
      .minor_o      (line),
      .major_o      (row)
   );

   osd_pixel #(
      .COLS     (COLS),
      .ROWS     (ROWS),
      .CELL_H   (CELL_H),
      .HALF_W   (HALF_W),
      .CODE_W   (CODE_W),
      .PAL_W    (PAL_W),
      .PX_W     (PX_W),
      .LINE_W   (LINE_W),
      .LEFT_MSB (LEFT_MSB)
   ) u_pixel (
      .clk         (clk),
      .rst_n       (rst_n),
      .osd_en_i    (osd_en_i),
      .mesh_en_i   (mesh_en_i),
      .ht_en_i     (ht_en_i),
      .bg_i        (bg_i),
      .pal_i       (pal_i),
      .hact_i      (hact),
      .px_i        (px),
      .col_i       (col),
      .vact_i      (vact),
      .line_i      (line),
      .row_i       (row),
      .disp_addr_o (disp_addr_o),
      .disp_data_i (disp_data_i),
      .font_addr_o (font_addr_o),
      .font_data_i (font_data_i),
      .pix_o       (pix)
   );

   assign {r_o, g_o, b_o} = pix.rgb;
   assign blank_o         = pix.blank;
   assign ht_o            = pix.ht;

   // R1: a frame edge wins over a simultaneous line edge; the row tracker restarts
   a_r1_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_rise && v_org_i != '0) |=> !vact);

endmodule

// File: tb/sim_osd_chargen.sv
`timescale 1ns/1ps
module sim_osd_chargen;

   localparam int COLS   = 4;
   localparam int ROWS   = 3;
   localparam int CELL_W = 14;
   localparam int CELL_H = 5;
   localparam int H_TOT  = 80;
   localparam int DAW    = $clog2(ROWS * COLS);
   localparam int FAW    = $clog2(256 * 2 * CELL_H);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync = 1'b0, vsync = 1'b0;
   logic        en = 1'b0, mesh = 1'b0, hten = 1'b0;
   logic [9:0]  horg = '0;
   logic [8:0]  vorg = '0;
   logic [3:0]  gap = '0;
   logic [2:0]  bg = '0;
   logic [23:0] pal = 24'hFAC688;

   logic [DAW-1:0] disp_addr;
   logic [10:0]    disp_data;
   logic [FAW-1:0] font_addr;
   logic [6:0]     font_data;
   logic           r, g, b, blank, ht;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [10:0] dmem(int a);
      int code, idx;
      code = (a * 37 + 5) % 256;
      idx  = (a * 3 + 1) % 8;
      return {3'(idx), 8'(code)};
   endfunction

   function automatic logic [6:0] fmem(int a);
      return 7'((a * 29) ^ (a >> 3));
   endfunction

   assign disp_data = dmem(int'(disp_addr));
   assign font_data = fmem(int'(font_addr));

   osd_chargen #(
      .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
      .osd_en_i(en), .mesh_en_i(mesh), .ht_en_i(hten),
      .h_org_i(horg), .v_org_i(vorg), .gap_i(gap), .bg_i(bg), .pal_i(pal),
      .disp_addr_o(disp_addr), .disp_data_i(disp_data),
      .font_addr_o(font_addr), .font_data_i(font_data),
      .r_o(r), .g_o(g), .b_o(b), .blank_o(blank), .ht_o(ht)
   );

   task automatic check(string tag, logic [4:0] act, logic [4:0] exp, int x, int L);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s x=%0d line=%0d got {rgb,blank,ht}=%b expected %b",
                  tag, x, L, act, exp);
      end
   endtask

   // Expected pixel {r,g,b,blank,ht} at pixel count x of raster line L.
   task automatic pixel_expect(int x, int L, output logic [4:0] e, output string tag);
      int xr, yr, pitch, line, row, col, px, a, code, idx, half, sub, fa;
      logic [10:0] dd;
      logic [6:0]  fd;
      e = '0;
      if (!en) begin tag = "R11"; return; end
      xr = x - int'(horg);
      yr = L - int'(vorg);
      pitch = CELL_H + int'(gap);
      if (xr < 0 || xr >= COLS * CELL_W || yr < 0 || yr >= ROWS * pitch) begin
         tag = "R1/R2"; return;
      end
      row  = yr / pitch;
      line = yr % pitch;
      if (line >= CELL_H) begin tag = "R3"; return; end
      col  = xr / CELL_W;
      px   = xr % CELL_W;
      a    = row * COLS + col;                       // R4 address
      dd   = dmem(a);
      code = int'(dd[7:0]);
      idx  = int'(dd[10:8]);
      half = (px >= 7) ? 1 : 0;
      sub  = px % 7;
      fa   = code * 2 * CELL_H + line * 2 + half;    // R5 address
      fd   = fmem(fa);
      if (fd[6 - sub]) begin                         // R6 bit order
         e = {pal[idx*3 +: 3], 1'b1, 1'b0};
         tag = "R4/R5/R6/R7";
      end else if (mesh && (((px ^ line) & 1) == 1)) begin
         e = {3'b000, 1'b0, hten};
         tag = "R9/R10";
      end else begin
         e = {bg, 1'b1, hten};
         tag = "R8/R10";
      end
   endtask

   task automatic run_frame(int g_, int vo, int ho, bit me, bit he, bit on, int bgc);
      int n;
      logic [4:0] e;
      string tag;
      gap = 4'(g_); vorg = 9'(vo); horg = 10'(ho);
      mesh = me; hten = he; en = on; bg = 3'(bgc);
      n = vo + ROWS * (CELL_H + g_) + 2;
      for (int L = 0; L < n; L++) begin
         for (int c = 0; c < H_TOT; c++) begin
            @(negedge clk);
            if (c >= 2) begin
               pixel_expect(c - 2, L, e, tag);
               check(tag, {r, g, b, blank, ht}, e, c - 2, L);
            end
            hsync = (c < 4);
            vsync = (L < 2);
         end
      end
   endtask

   initial begin
      en = 1'b1;
      repeat (3) @(negedge clk);
      check("R12", {r, g, b, blank, ht}, 5'b0, -1, -1);
      rst_n = 1'b1;
      repeat (5) begin
         @(negedge clk);
         check("R12", {r, g, b, blank, ht}, 5'b0, -1, -1);
      end
      // Sweep of every row gap with assorted origins and background colours.
      for (int gg = 0; gg < 16; gg++)
         run_frame(gg, gg % 4, (gg % 3) * 5, 1'b0, 1'b0, 1'b1, gg % 8);
      run_frame(3, 2, 7, 1'b1, 1'b0, 1'b1, 5);    // R9 mesh
      run_frame(0, 0, 0, 1'b1, 1'b1, 1'b1, 2);    // R9/R10 mesh with half-tone, zero origins
      run_frame(15, 1, 20, 1'b0, 1'b1, 1'b1, 7);  // R10 solid half-tone, widest gap
      run_frame(2, 1, 4, 1'b1, 1'b1, 1'b0, 6);    // R11 disabled
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired after 200000 cycles");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule